// File: doc/BRIEF.md
# Linked Pair of Gated Retriggerable Down-Counters

This block holds two 16-bit down-counting channels. Each channel copies a programmed reload value into its counter when it is triggered, then counts toward zero. A per-channel mode bit picks the counting clock. In timer mode the channel counts once every two system clock cycles. In counter mode it counts once per rising edge of an external count pin. Reaching zero raises a one-count-period output pulse and sets a sticky completion flag. A further bit makes the channel reload itself at zero and run without stopping.

Any of several sources can start a channel. The sources are combined into one level, and only a rising edge of that combined level counts as a trigger. A source that stays high therefore hides the edges of the others. Counting also needs every enabled gate source to be high: software, an optional external pin and an optional link from the first channel. The gate never blocks a trigger.

The second channel can take two extra sources from the first channel's output. It can be triggered by the falling edge of that output, and it can be held while that output is high. Each of these links has its own enable bit. All external pins are resynchronised to the system clock.

Top module: `ctmr_pair`

## Requirements
- R1: After a synchronous reset, every channel reads a count of 0, with its output pulse and completion flag both low.
- R2: A trigger is a rising edge of the combined trigger level. The sources are the synchronised external trigger pin, a one-cycle software trigger strobe and, on channel 1 only, the link. A trigger arms a pending load. The reload value is copied into the count on the next counting tick. The load takes place even while the gate is closed.
- R3: In timer mode (count-select bit 0), a running, gated-open channel decrements exactly once for every two system clock cycles.
- R4: In counter mode (count-select bit 1), a running, gated-open channel decrements once for each rising edge of its external count pin, seen after a two-flop synchroniser.
- R5: While one trigger source is held high, a rising edge on another source does not reload the channel. A new trigger is accepted once the held source has returned low.
- R6: The channel counts only when the software gate is 1 and, if the external-gate enable is 1, the external gate pin is also 1. While the external-gate enable is 0, the external gate pin has no effect.
- R7: The tick that takes the count from 1 to its terminal value raises the output for exactly one counting period and sets the completion flag. The flag stays set until a software clear strobe.
- R8: In one-shot mode (continuous bit 0), the channel stops at a count of 0 until it is triggered again. In continuous mode it reloads the reload value on the terminal tick.
- R9: A reload value of 0 stands for 65536 counts. Loading it does not end the count, and the first tick after it gives 0xFFFF.
- R10: When the link-trigger enable is 1, a falling edge of channel 0's output triggers channel 1. When that enable is 0, the falling edge has no effect on channel 1.
- R11: When the link-gate enable is 1, channel 1 holds its count while channel 0's output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig_i | input | 2 | External trigger pin per channel (asynchronous) |
| ext_gate_i | input | 2 | External gate pin per channel (asynchronous) |
| ext_cnt_i | input | 2 | External count pin per channel (asynchronous) |
| sw_trig_i | input | 2 | Software trigger strobe per channel, one cycle |
| sw_gate_i | input | 2 | Software gate bit per channel |
| sw_done_clr_i | input | 2 | Completion flag clear strobe per channel |
| cnt_mode_i | input | 2 | Count select per channel: 0 timer, 1 external count pin |
| xgate_en_i | input | 2 | External gate pin enable per channel |
| cont_i | input | 2 | Continuous reload per channel |
| link_trig_en_i | input | 1 | Channel 0 output falling edge triggers channel 1 |
| link_gate_en_i | input | 1 | Channel 0 output high holds channel 1 |
| tconst_i | input | 2x16 | Reload value per channel |
| tc_out_o | output | 2 | Terminal pulse per channel |
| done_o | output | 2 | Sticky completion flag per channel |
| count_o | output | 2x16 | Current count per channel |

## Verification
The assertions assume that the software strobes for trigger and clear last a single system clock cycle. They also assume that the reload value and the mode bits are steady around the tick that uses them. The external pins may be asynchronous, because the properties only watch the synchronised, registered versions. The stimulus changes every input on the falling clock edge, pulses the strobes for one cycle, and holds each external count level for three cycles so that each edge gets through the synchroniser cleanly. Mode and reload values are changed only while the channel is waiting for a trigger or has stopped.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CTMR_NCH   = 2;
    localparam int CTMR_CNT_W = 16;

    typedef struct packed {
        logic cnt_mode;   // 1: count external pin edges, 0: half system clock
        logic xgate_en;   // external gate pin participates in the gate AND
        logic cont;       // reload at terminal count
    } chan_cfg_t;

    typedef struct packed {
        logic trig;
        logic gate;
        logic cnt;
    } pin_set_t;

    function automatic logic up_edge(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/ctmr_sync.sv
module ctmr_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [1:0] stage_q;
        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= {stage_q[0], d_i[b]};
        end
        assign q_o[b] = stage_q[1];
    end
endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
    import ctmr_pkg::*;
#(
    parameter int CNT_W = CTMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        cfg_i,
    input  pin_set_t         pins_i,      // already synchronised levels
    input  logic             sw_trig_i,
    input  logic             sw_gate_i,
    input  logic             sw_clr_i,
    input  logic [CNT_W-1:0] tconst_i,
    input  logic             link_trig_i, // one-cycle pulse
    input  logic             link_gate_i, // 1 when link does not hold
    output logic             out_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             half_q, cnt_prev_q, trig_prev_q;
    logic             pend_q, run_q, out_q, done_q;
    logic [CNT_W-1:0] count_q;
    logic             tick, trig_lvl, trig_hit, gate_open, term_hit;

    assign tick      = cfg_i.cnt_mode ? up_edge(pins_i.cnt, cnt_prev_q) : half_q;
    assign trig_lvl  = pins_i.trig | sw_trig_i | link_trig_i;
    assign trig_hit  = up_edge(trig_lvl, trig_prev_q);
    assign gate_open = sw_gate_i & (~cfg_i.xgate_en | pins_i.gate) & link_gate_i;
    assign term_hit  = tick & ~pend_q & run_q & gate_open & (count_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q      <= 1'b0;
            cnt_prev_q  <= 1'b0;
            trig_prev_q <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            half_q      <= ~half_q;
            cnt_prev_q  <= pins_i.cnt;
            trig_prev_q <= trig_lvl;
            pend_q      <= trig_hit | (pend_q & ~tick);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
            out_q   <= 1'b0;
        end else if (tick) begin
            out_q <= 1'b0;
            if (pend_q) begin
                count_q <= tconst_i;
                run_q   <= 1'b1;
            end else if (run_q && gate_open) begin
                if (count_q == ONE) begin
                    out_q <= 1'b1;
                    if (cfg_i.cont) begin
                        count_q <= tconst_i;
                    end else begin
                        count_q <= '0;
                        run_q   <= 1'b0;
                    end
                end else begin
                    count_q <= count_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           done_q <= 1'b0;
        else if (term_hit) done_q <= 1'b1;
        else if (sw_clr_i) done_q <= 1'b0;
    end

    assign out_o   = out_q;
    assign done_o  = done_q;
    assign count_o = count_q;

    // R2: a pending trigger loads the reload value on the tick
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && pend_q) |=> (count_q == $past(tconst_i)));

    // R6: closed gate freezes the count when no load is pending
    p_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend_q && !gate_open) |=> $stable(count_q));

    // R3/R4: one step down per accepted tick
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend_q && run_q && gate_open && count_q != ONE)
        |=> (count_q == $past(count_q) - ONE));

    // R7: a rising terminal pulse always comes with the completion flag
    p_flag_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> done_q);

    // R8: one-shot terminal leaves the count at zero
    p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_q) && !$past(cfg_i.cont)) |-> (count_q == '0));
endmodule

// File: rtl/ctmr_pair.sv
module ctmr_pair
    import ctmr_pkg::*;
#(
    parameter int CNT_W = CTMR_CNT_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [CTMR_NCH-1:0]             ext_trig_i,
    input  logic [CTMR_NCH-1:0]             ext_gate_i,
    input  logic [CTMR_NCH-1:0]             ext_cnt_i,
    input  logic [CTMR_NCH-1:0]             sw_trig_i,
    input  logic [CTMR_NCH-1:0]             sw_gate_i,
    input  logic [CTMR_NCH-1:0]             sw_done_clr_i,
    input  logic [CTMR_NCH-1:0]             cnt_mode_i,
    input  logic [CTMR_NCH-1:0]             xgate_en_i,
    input  logic [CTMR_NCH-1:0]             cont_i,
    input  logic                            link_trig_en_i,
    input  logic                            link_gate_en_i,
    input  logic [CTMR_NCH-1:0][CNT_W-1:0]  tconst_i,
    output logic [CTMR_NCH-1:0]             tc_out_o,
    output logic [CTMR_NCH-1:0]             done_o,
    output logic [CTMR_NCH-1:0][CNT_W-1:0]  count_o
);
    logic out0_prev_q;
    logic out0_fall;

    always_ff @(posedge clk) begin
        if (rst) out0_prev_q <= 1'b0;
        else     out0_prev_q <= tc_out_o[0];
    end
    assign out0_fall = out0_prev_q & ~tc_out_o[0];

    for (genvar c = 0; c < CTMR_NCH; c++) begin : g_ch
        pin_set_t  pins_s;
        chan_cfg_t cfg;
        logic      l_trig, l_gate;

        ctmr_sync #(.W(3)) i_sync (
            .clk (clk),
            .rst (rst),
            .d_i ({ext_trig_i[c], ext_gate_i[c], ext_cnt_i[c]}),
            .q_o (pins_s)
        );

        assign cfg = '{cnt_mode: cnt_mode_i[c], xgate_en: xgate_en_i[c], cont: cont_i[c]};

        if (c == 1) begin : g_linked
            assign l_trig = link_trig_en_i & out0_fall;
            assign l_gate = ~(link_gate_en_i & tc_out_o[0]);
        end else begin : g_free
            assign l_trig = 1'b0;
            assign l_gate = 1'b1;
        end

        ctmr_channel #(.CNT_W(CNT_W)) i_chan (
            .clk         (clk),
            .rst         (rst),
            .cfg_i       (cfg),
            .pins_i      (pins_s),
            .sw_trig_i   (sw_trig_i[c]),
            .sw_gate_i   (sw_gate_i[c]),
            .sw_clr_i    (sw_done_clr_i[c]),
            .tconst_i    (tconst_i[c]),
            .link_trig_i (l_trig),
            .link_gate_i (l_gate),
            .out_o       (tc_out_o[c]),
            .done_o      (done_o[c]),
            .count_o     (count_o[c])
        );
    end

    // R10: with the trigger link off, channel 0's falling output cannot arm channel 1
    p_link_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!link_trig_en_i) |-> !g_ch[1].l_trig);
endmodule

// File: tb/test_ctmr_pair.sv
`timescale 1ns/1ps
module test_ctmr_pair;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0] ext_trig = '0, ext_gate = '0, ext_cnt = '0;
    logic [1:0] sw_trig = '0, sw_gate = 2'b11, sw_clr = '0;
    logic [1:0] cnt_mode = 2'b11, xgate_en = '0, cont = '0;
    logic       l_trig_en = 1'b0, l_gate_en = 1'b0;
    logic [1:0][15:0] tconst = '0;
    logic [1:0]       tc_out, done;
    logic [1:0][15:0] count;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    ctmr_pair i_ctmr_pair (
        .clk(clk), .rst(rst),
        .ext_trig_i(ext_trig), .ext_gate_i(ext_gate), .ext_cnt_i(ext_cnt),
        .sw_trig_i(sw_trig), .sw_gate_i(sw_gate), .sw_done_clr_i(sw_clr),
        .cnt_mode_i(cnt_mode), .xgate_en_i(xgate_en), .cont_i(cont),
        .link_trig_en_i(l_trig_en), .link_gate_en_i(l_gate_en),
        .tconst_i(tconst), .tc_out_o(tc_out), .done_o(done), .count_o(count)
    );

    // fields: reload value, extra ticks after load, expected count, expected terminal
    localparam logic [48:0] VECS [6] = '{
        {16'd10,  16'd3,   16'd7,      1'b0},
        {16'd5,   16'd5,   16'd0,      1'b1},
        {16'd1,   16'd1,   16'd0,      1'b1},
        {16'd0,   16'd1,   16'hFFFF,   1'b0},
        {16'd300, 16'd100, 16'd200,    1'b0},
        {16'd2,   16'd1,   16'd1,      1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_cnt(input int ch);
        @(negedge clk) ext_cnt[ch] = 1'b1;
        repeat (3) @(negedge clk);
        ext_cnt[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe_trig(input int ch);
        @(negedge clk) sw_trig[ch] = 1'b1;
        @(negedge clk) sw_trig[ch] = 1'b0;
    endtask

    task automatic strobe_clr(input int ch);
        @(negedge clk) sw_clr[ch] = 1'b1;
        @(negedge clk) sw_clr[ch] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count0", count[0], 0);
        chk("R1 count1", count[1], 0);
        chk("R1 out",    tc_out, 0);
        chk("R1 done",   done, 0);

        // table walk, channel 0 in counter mode (R4, R7, R8, R9)
        for (int v = 0; v < 6; v++) begin
            strobe_clr(0);
            tconst[0] = VECS[v][48:33];
            strobe_trig(0);
            pulse_cnt(0);
            for (int k = 0; k < int'(VECS[v][32:17]); k++) pulse_cnt(0);
            chk("R4 table count", count[0], int'(VECS[v][16:1]));
            chk("R7 table out",   tc_out[0], int'(VECS[v][0]));
            chk("R7 table done",  done[0], int'(VECS[v][0]));
        end

        // R7 / R8 one-shot: out lasts one period, count stays at 0
        tconst[0] = 16'd5;
        strobe_clr(0);
        strobe_trig(0);
        repeat (6) pulse_cnt(0);
        chk("R7 out high", tc_out[0], 1);
        pulse_cnt(0);
        chk("R7 out one period", tc_out[0], 0);
        chk("R8 stopped at zero", count[0], 0);
        chk("R7 done sticky", done[0], 1);
        strobe_clr(0);
        chk("R7 done cleared", done[0], 0);

        // R8 continuous reload
        cont[0] = 1'b1;
        tconst[0] = 16'd3;
        strobe_trig(0);
        repeat (4) pulse_cnt(0);
        chk("R8 reload", count[0], 3);
        chk("R8 out", tc_out[0], 1);
        pulse_cnt(0);
        chk("R8 continues", count[0], 2);
        cont[0] = 1'b0;

        // R3 timer mode
        tconst[0] = 16'd100;
        cnt_mode[0] = 1'b0;
        strobe_trig(0);
        repeat (4) @(negedge clk);
        c0 = count[0];
        repeat (20) @(negedge clk);
        chk("R3 half rate", count[0], c0 - 10);
        cnt_mode[0] = 1'b1;
        repeat (2) @(negedge clk);

        // R6 gate AND, R2 load while gate closed
        tconst[0] = 16'd20;
        strobe_trig(0);
        pulse_cnt(0);
        sw_gate[0] = 1'b0;
        repeat (2) pulse_cnt(0);
        chk("R6 sw gate holds", count[0], 20);
        tconst[0] = 16'd30;
        strobe_trig(0);
        pulse_cnt(0);
        chk("R2 load with gate closed", count[0], 30);
        sw_gate[0] = 1'b1;
        xgate_en[0] = 1'b1;
        ext_gate[0] = 1'b0;
        repeat (2) pulse_cnt(0);
        chk("R6 ext gate holds", count[0], 30);
        xgate_en[0] = 1'b0;
        pulse_cnt(0);
        chk("R6 ext gate ignored when disabled", count[0], 29);
        ext_gate[0] = 1'b1;
        xgate_en[0] = 1'b1;
        repeat (3) @(negedge clk);
        pulse_cnt(0);
        chk("R6 ext gate open", count[0], 28);
        xgate_en[0] = 1'b0;

        // R5 held trigger masks others
        tconst[0] = 16'd50;
        strobe_trig(0);
        repeat (3) pulse_cnt(0);
        chk("R5 setup", count[0], 48);
        @(negedge clk) ext_trig[0] = 1'b1;
        repeat (4) @(negedge clk);
        pulse_cnt(0);
        chk("R2 ext trigger load", count[0], 50);
        pulse_cnt(0);
        strobe_trig(0);
        pulse_cnt(0);
        chk("R5 masked sw trigger", count[0], 48);
        @(negedge clk) ext_trig[0] = 1'b0;
        repeat (4) @(negedge clk);
        strobe_trig(0);
        pulse_cnt(0);
        chk("R5 accepted after release", count[0], 50);

        // R10 / R11 linking
        l_trig_en = 1'b1;
        tconst[0] = 16'd2;
        tconst[1] = 16'd9;
        strobe_trig(0);
        repeat (3) pulse_cnt(0);
        chk("R10 ch0 terminal", tc_out[0], 1);
        pulse_cnt(0);
        pulse_cnt(1);
        chk("R10 ch1 linked load", count[1], 9);
        pulse_cnt(1);
        chk("R10 ch1 counts", count[1], 8);
        l_trig_en = 1'b0;
        l_gate_en = 1'b1;
        strobe_trig(0);
        repeat (3) pulse_cnt(0);
        pulse_cnt(1);
        chk("R11 ch1 held by ch0 output", count[1], 8);
        pulse_cnt(0);
        pulse_cnt(1);
        chk("R10 no link trigger when disabled", count[1], 7);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule